// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Multicycle Datapath

This block is the control unit of a multicycle processor datapath, written as a microprogram instead of a hand-built state machine. A 4-bit micro-address register selects one word out of ten held in a constant microinstruction store. The 18-bit word carries seven fields, and these are expanded into the individual select and enable lines that the datapath expects. The current micro-address is also exposed, so the datapath and tests can see where the control sequence stands.

Each cycle, a 2-bit sequencing field in the current word chooses the next micro-address. It can go back to the fetch word, step to the following word, or take a target from one of two constant 64-entry tables indexed by the 6-bit instruction opcode. The first table sends the shared decode step to the start of each instruction class. The second table splits memory-reference instructions into their load and store tails. Any opcode that a table does not recognise maps to address 0, so unknown instructions simply start a new fetch.

Top module: `ucode_sequencer`

## Requirements
- R1: A high `rst` at a rising clock edge sets `upc` to 0 at that edge. This holds whatever the current word is, and the reset is synchronous.
- R2: At `upc`=0 the outputs are as follows. mem_read=1, ir_write=1, i_or_d=0, alu_src_a=0, alu_src_b=01, alu_op=00, pc_write=1, pc_source=00, and every other control output is 0. The next `upc` is 1.
- R3: At `upc`=1, alu_src_b=11 and every other control output is 0. The next `upc` comes from the first table: opcode 0x23 and 0x2B give 2, 0x00 gives 6, 0x04 gives 8 and 0x02 gives 9.
- R4: At `upc`=2, alu_src_a=1, alu_src_b=10 and every other control output is 0. The next `upc` comes from the second table: opcode 0x23 gives 3 and 0x2B gives 5.
- R5: In either table, an opcode with no listed entry gives a next `upc` of 0.
- R6: At `upc`=3, mem_read=1 and i_or_d=1, and the next `upc` is 4. At `upc`=4, reg_write=1 and mem_to_reg=1, and the next `upc` is 0. All other control outputs are 0 at both addresses.
- R7: At `upc`=5, mem_write=1 and i_or_d=1, all other control outputs are 0, and the next `upc` is 0.
- R8: At `upc`=6, alu_op=10 and alu_src_a=1, and the next `upc` is 7. At `upc`=7, reg_write=1 and reg_dst=1, and the next `upc` is 0. All other control outputs are 0 at both addresses.
- R9: At `upc`=8, alu_op=01, alu_src_a=1, pc_write_cond=1 and pc_source=01. All other control outputs are 0, and the next `upc` is 0.
- R10: At `upc`=9, pc_write=1 and pc_source=10, all other control outputs are 0, and the next `upc` is 0.
- R11: The opcode has no effect on the next `upc` at any address other than 1 and 2.
- R12: mem_read and mem_write are never both 1. pc_write and pc_write_cond are never both 1. ir_write is 1 only at `upc`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode of the instruction held by the datapath |
| upc | output | 4 | Current micro-address |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| alu_src_a | output | 1 | First ALU operand: 0 PC, 1 register A |
| alu_src_b | output | 2 | Second operand: 00 B, 01 four, 10 extended immediate, 11 shifted immediate |
| reg_write | output | 1 | Register file write enable |
| reg_dst | output | 1 | Write register number: 0 rt field, 1 rd field |
| mem_to_reg | output | 1 | Register write data: 0 ALU result register, 1 memory data register |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| i_or_d | output | 1 | Memory address: 0 PC, 1 ALU result register |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC load |
| pc_write_cond | output | 1 | PC load qualified by the ALU zero flag |
| pc_source | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |

## Verification
The clocked properties assume that `rst` is held high from time zero through at least one rising edge, so `upc` is always known once they are enabled. Apart from that they make no assumption about the opcode: it may take any value in any cycle. The stimulus relies on this. Besides the five supported opcodes, it applies two unlisted ones, and it changes the opcode between micro-steps in the middle of an instruction, so the table lookups and the cases where the opcode must be ignored are both reached.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int unsigned OPC_W       = 6;
    localparam int unsigned UADDR_W     = 4;
    localparam int unsigned UCODE_DEPTH = 10;
    localparam int unsigned OPC_COUNT   = 1 << OPC_W;

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OP_JUMP  = 6'h02;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

    localparam logic [UADDR_W-1:0] UA_FETCH  = 4'd0;
    localparam logic [UADDR_W-1:0] UA_DECODE = 4'd1;
    localparam logic [UADDR_W-1:0] UA_EADDR  = 4'd2;
    localparam logic [UADDR_W-1:0] UA_LDMEM  = 4'd3;
    localparam logic [UADDR_W-1:0] UA_LDWB   = 4'd4;
    localparam logic [UADDR_W-1:0] UA_STMEM  = 4'd5;
    localparam logic [UADDR_W-1:0] UA_REXE   = 4'd6;
    localparam logic [UADDR_W-1:0] UA_RWB    = 4'd7;
    localparam logic [UADDR_W-1:0] UA_BEQ    = 4'd8;
    localparam logic [UADDR_W-1:0] UA_JMP    = 4'd9;

    typedef enum logic [1:0] {SQ_FETCH, SQ_DISP1, SQ_DISP2, SQ_NEXT} seq_sel_e;
    typedef enum logic [1:0] {AL_ADD, AL_SUB, AL_FUNCT} alu_fld_e;
    typedef enum logic [1:0] {S2_B, S2_FOUR, S2_IMM, S2_IMM_SH} src2_fld_e;
    typedef enum logic [2:0] {RG_NONE, RG_RD_ALU, RG_RT_MDR} reg_fld_e;
    typedef enum logic [3:0] {MM_NONE, MM_FETCH, MM_RD_ALU, MM_WR_ALU} mem_fld_e;
    typedef enum logic [3:0] {PW_NONE, PW_ALU, PW_COND, PW_JUMP} pcw_fld_e;

    typedef struct packed {
        alu_fld_e  alu;
        logic      src1;
        src2_fld_e src2;
        reg_fld_e  rg;
        mem_fld_e  mem;
        pcw_fld_e  pcw;
        seq_sel_e  seq;
    } micro_word_t;

    localparam int unsigned UWORD_W = $bits(micro_word_t);

    typedef struct packed {
        logic [1:0] alu_op;
        logic       alu_src_a;
        logic [1:0] alu_src_b;
        logic       reg_write;
        logic       reg_dst;
        logic       mem_to_reg;
        logic       mem_read;
        logic       mem_write;
        logic       i_or_d;
        logic       ir_write;
        logic       pc_write;
        logic       pc_write_cond;
        logic [1:0] pc_source;
    } ctl_lines_t;

    function automatic micro_word_t uw(input alu_fld_e a, input logic s1,
                                       input src2_fld_e s2, input reg_fld_e r,
                                       input mem_fld_e m, input pcw_fld_e p,
                                       input seq_sel_e q);
        micro_word_t w;
        w.alu  = a;
        w.src1 = s1;
        w.src2 = s2;
        w.rg   = r;
        w.mem  = m;
        w.pcw  = p;
        w.seq  = q;
        return w;
    endfunction

    function automatic micro_word_t ucode_word(input logic [UADDR_W-1:0] addr);
        case (addr)
            UA_FETCH:  return uw(AL_ADD,   1'b0, S2_FOUR,   RG_NONE,   MM_FETCH,  PW_ALU,  SQ_NEXT);
            UA_DECODE: return uw(AL_ADD,   1'b0, S2_IMM_SH, RG_NONE,   MM_NONE,   PW_NONE, SQ_DISP1);
            UA_EADDR:  return uw(AL_ADD,   1'b1, S2_IMM,    RG_NONE,   MM_NONE,   PW_NONE, SQ_DISP2);
            UA_LDMEM:  return uw(AL_ADD,   1'b0, S2_B,      RG_NONE,   MM_RD_ALU, PW_NONE, SQ_NEXT);
            UA_LDWB:   return uw(AL_ADD,   1'b0, S2_B,      RG_RT_MDR, MM_NONE,   PW_NONE, SQ_FETCH);
            UA_STMEM:  return uw(AL_ADD,   1'b0, S2_B,      RG_NONE,   MM_WR_ALU, PW_NONE, SQ_FETCH);
            UA_REXE:   return uw(AL_FUNCT, 1'b1, S2_B,      RG_NONE,   MM_NONE,   PW_NONE, SQ_NEXT);
            UA_RWB:    return uw(AL_ADD,   1'b0, S2_B,      RG_RD_ALU, MM_NONE,   PW_NONE, SQ_FETCH);
            UA_BEQ:    return uw(AL_SUB,   1'b1, S2_B,      RG_NONE,   MM_NONE,   PW_COND, SQ_FETCH);
            UA_JMP:    return uw(AL_ADD,   1'b0, S2_B,      RG_NONE,   MM_NONE,   PW_JUMP, SQ_FETCH);
            default:   return uw(AL_ADD,   1'b0, S2_B,      RG_NONE,   MM_NONE,   PW_NONE, SQ_FETCH);
        endcase
    endfunction

    function automatic logic [UADDR_W-1:0] disp_entry(input int unsigned table_id,
                                                      input logic [OPC_W-1:0] opc);
        if (table_id == 1) begin
            case (opc)
                OP_LOAD, OP_STORE: return UA_EADDR;
                OP_RTYPE:          return UA_REXE;
                OP_BEQ:            return UA_BEQ;
                OP_JUMP:           return UA_JMP;
                default:           return UA_FETCH;
            endcase
        end else begin
            case (opc)
                OP_LOAD:  return UA_LDMEM;
                OP_STORE: return UA_STMEM;
                default:  return UA_FETCH;
            endcase
        end
    endfunction

endpackage

// File: rtl/ucode_store.sv
module ucode_store
    import ucode_pkg::*;
#(
    parameter int unsigned ADDR_W = UADDR_W,
    parameter int unsigned DEPTH  = UCODE_DEPTH
) (
    input  logic [ADDR_W-1:0] addr,
    output micro_word_t       word
);
    localparam int unsigned SLOTS = 1 << ADDR_W;

    micro_word_t rom [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < DEPTH) begin : g_used
            assign rom[g] = ucode_word(UADDR_W'(g));
        end else begin : g_spare
            assign rom[g] = uw(AL_ADD, 1'b0, S2_B, RG_NONE, MM_NONE, PW_NONE, SQ_FETCH);
        end
    end

    assign word = rom[addr];
endmodule

// File: rtl/dispatch_table.sv
module dispatch_table
    import ucode_pkg::*;
#(
    parameter int unsigned TABLE_ID = 1,
    parameter int unsigned OP_W     = OPC_W,
    parameter int unsigned ADDR_W   = UADDR_W
) (
    input  logic [OP_W-1:0]   opc,
    output logic [ADDR_W-1:0] target
);
    localparam int unsigned ENTRIES = 1 << OP_W;

    logic [ADDR_W-1:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign tbl[g] = ADDR_W'(disp_entry(TABLE_ID, OPC_W'(g)));
    end

    assign target = tbl[opc];
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
    import ucode_pkg::*;
(
    input  micro_word_t word,
    output ctl_lines_t  ctl
);
    always_comb begin
        ctl           = '0;
        ctl.alu_op    = word.alu;
        ctl.alu_src_a = word.src1;
        ctl.alu_src_b = word.src2;

        case (word.rg)
            RG_RD_ALU: begin
                ctl.reg_write = 1'b1;
                ctl.reg_dst   = 1'b1;
            end
            RG_RT_MDR: begin
                ctl.reg_write  = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            default: ;
        endcase

        case (word.mem)
            MM_FETCH: begin
                ctl.mem_read = 1'b1;
                ctl.ir_write = 1'b1;
            end
            MM_RD_ALU: begin
                ctl.mem_read = 1'b1;
                ctl.i_or_d   = 1'b1;
            end
            MM_WR_ALU: begin
                ctl.mem_write = 1'b1;
                ctl.i_or_d    = 1'b1;
            end
            default: ;
        endcase

        case (word.pcw)
            PW_ALU: begin
                ctl.pc_write  = 1'b1;
                ctl.pc_source = 2'b00;
            end
            PW_COND: begin
                ctl.pc_write_cond = 1'b1;
                ctl.pc_source     = 2'b01;
            end
            PW_JUMP: begin
                ctl.pc_write  = 1'b1;
                ctl.pc_source = 2'b10;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import ucode_pkg::*;
#(
    parameter int unsigned OP_W   = OPC_W,
    parameter int unsigned ADDR_W = UADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] upc,
    output logic [1:0]        alu_op,
    output logic              alu_src_a,
    output logic [1:0]        alu_src_b,
    output logic              reg_write,
    output logic              reg_dst,
    output logic              mem_to_reg,
    output logic              mem_read,
    output logic              mem_write,
    output logic              i_or_d,
    output logic              ir_write,
    output logic              pc_write,
    output logic              pc_write_cond,
    output logic [1:0]        pc_source
);
    logic [ADDR_W-1:0] upc_q;
    logic [ADDR_W-1:0] upc_d;
    logic [ADDR_W-1:0] disp1_tgt;
    logic [ADDR_W-1:0] disp2_tgt;
    micro_word_t       word;
    ctl_lines_t        ctl;

    ucode_store #(.ADDR_W(ADDR_W), .DEPTH(UCODE_DEPTH)) u_store (
        .addr (upc_q),
        .word (word)
    );

    dispatch_table #(.TABLE_ID(1), .OP_W(OP_W), .ADDR_W(ADDR_W)) u_disp1 (
        .opc    (opcode),
        .target (disp1_tgt)
    );

    dispatch_table #(.TABLE_ID(2), .OP_W(OP_W), .ADDR_W(ADDR_W)) u_disp2 (
        .opc    (opcode),
        .target (disp2_tgt)
    );

    ctl_decode u_dec (
        .word (word),
        .ctl  (ctl)
    );

    always_comb begin
        case (word.seq)
            SQ_FETCH: upc_d = '0;
            SQ_DISP1: upc_d = disp1_tgt;
            SQ_DISP2: upc_d = disp2_tgt;
            default:  upc_d = upc_q + ADDR_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) upc_q <= '0;
        else     upc_q <= upc_d;
    end

    assign upc           = upc_q;
    assign alu_op        = ctl.alu_op;
    assign alu_src_a     = ctl.alu_src_a;
    assign alu_src_b     = ctl.alu_src_b;
    assign reg_write     = ctl.reg_write;
    assign reg_dst       = ctl.reg_dst;
    assign mem_to_reg    = ctl.mem_to_reg;
    assign mem_read      = ctl.mem_read;
    assign mem_write     = ctl.mem_write;
    assign i_or_d        = ctl.i_or_d;
    assign ir_write      = ctl.ir_write;
    assign pc_write      = ctl.pc_write;
    assign pc_write_cond = ctl.pc_write_cond;
    assign pc_source     = ctl.pc_source;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] opcode,
    input logic [3:0] upc,
    input logic       mem_read,
    input logic       mem_write,
    input logic       pc_write,
    input logic       pc_write_cond,
    input logic       ir_write
);
    logic op_known1;
    assign op_known1 = (opcode == 6'h00) || (opcode == 6'h02) || (opcode == 6'h04) ||
                       (opcode == 6'h23) || (opcode == 6'h2B);

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk) rst |=> upc == 4'd0);

    // R2
    fetch_steps_chk: assert property (@(posedge clk) disable iff (rst)
        upc == 4'd0 |=> upc == 4'd1);

    // R3
    disp1_rtype_chk: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd1 && opcode == 6'h00) |=> upc == 4'd6);

    // R4
    disp2_store_chk: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd2 && opcode == 6'h2B) |=> upc == 4'd5);

    // R5
    disp1_unknown_chk: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd1 && !op_known1) |=> upc == 4'd0);

    // R6
    load_mem_seq_chk: assert property (@(posedge clk) disable iff (rst)
        upc == 4'd3 |=> upc == 4'd4);

    // R10
    jump_return_chk: assert property (@(posedge clk) disable iff (rst)
        upc == 4'd9 |=> upc == 4'd0);

    // R12
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write));

    // R12
    pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_write && pc_write_cond));

    // R12
    ir_only_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        ir_write |-> upc == 4'd0);
endmodule

bind ucode_sequencer ucode_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .opcode        (opcode),
    .upc           (upc),
    .mem_read      (mem_read),
    .mem_write     (mem_write),
    .pc_write      (pc_write),
    .pc_write_cond (pc_write_cond),
    .ir_write      (ir_write)
);

// File: tb/tb_ucode_sequencer.sv
`timescale 1ns/1ps
module tb_ucode_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic [3:0] upc;
    logic [1:0] alu_op, alu_src_b, pc_source;
    logic       alu_src_a, reg_write, reg_dst, mem_to_reg, mem_read, mem_write;
    logic       i_or_d, ir_write, pc_write, pc_write_cond;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ucode_sequencer dut (
        .clk(clk), .rst(rst), .opcode(opcode), .upc(upc),
        .alu_op(alu_op), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
        .reg_write(reg_write), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
        .mem_read(mem_read), .mem_write(mem_write), .i_or_d(i_or_d),
        .ir_write(ir_write), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
        .pc_source(pc_source)
    );

    // {opcode[5:0], steps[2:0], addr4, addr3, addr2, addr1, addr0}
    localparam int NV = 7;
    localparam logic [28:0] VEC [NV] = '{
        {6'h23, 3'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0},
        {6'h2B, 3'd4, 4'd0, 4'd5, 4'd2, 4'd1, 4'd0},
        {6'h00, 3'd4, 4'd0, 4'd7, 4'd6, 4'd1, 4'd0},
        {6'h04, 3'd3, 4'd0, 4'd0, 4'd8, 4'd1, 4'd0},
        {6'h02, 3'd3, 4'd0, 4'd0, 4'd9, 4'd1, 4'd0},
        {6'h3F, 3'd2, 4'd0, 4'd0, 4'd0, 4'd1, 4'd0},
        {6'h08, 3'd2, 4'd0, 4'd0, 4'd0, 4'd1, 4'd0}
    };

    // {alu_op, src_a, src_b, reg_write, reg_dst, mem_to_reg, mem_read,
    //  mem_write, i_or_d, ir_write, pc_write, pc_write_cond, pc_source}
    function automatic logic [15:0] exp_ctl(input logic [3:0] a);
        case (a)
            4'd0: return {2'b00, 1'b0, 2'b01, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00};
            4'd1: return {2'b00, 1'b0, 2'b11, 3'b000, 6'b000000, 2'b00};
            4'd2: return {2'b00, 1'b1, 2'b10, 3'b000, 6'b000000, 2'b00};
            4'd3: return {2'b00, 1'b0, 2'b00, 3'b000, 1'b1, 1'b0, 1'b1, 3'b000, 2'b00};
            4'd4: return {2'b00, 1'b0, 2'b00, 3'b101, 6'b000000, 2'b00};
            4'd5: return {2'b00, 1'b0, 2'b00, 3'b000, 1'b0, 1'b1, 1'b1, 3'b000, 2'b00};
            4'd6: return {2'b10, 1'b1, 2'b00, 3'b000, 6'b000000, 2'b00};
            4'd7: return {2'b00, 1'b0, 2'b00, 3'b110, 6'b000000, 2'b00};
            4'd8: return {2'b01, 1'b1, 2'b00, 3'b000, 5'b00000, 1'b1, 2'b01};
            4'd9: return {2'b00, 1'b0, 2'b00, 3'b000, 4'b0000, 1'b1, 1'b0, 2'b10};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd4: return "R6";
            4'd5: return "R7";
            4'd6, 4'd7: return "R8";
            4'd8: return "R9";
            4'd9: return "R10";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_state(input string req, input logic [3:0] exp_upc);
        logic [15:0] got;
        got = {alu_op, alu_src_a, alu_src_b, reg_write, reg_dst, mem_to_reg,
               mem_read, mem_write, i_or_d, ir_write, pc_write, pc_write_cond, pc_source};
        check(req, "upc", {12'h0, upc}, {12'h0, exp_upc});
        check(req_of(exp_upc), "controls", got, exp_ctl(exp_upc));
        check("R12", "exclusive enables",
              {14'h0, mem_read & mem_write, pc_write & pc_write_cond}, 16'h0);
    endtask

    // Check the current step, apply the opcode for this cycle, advance one cycle.
    task automatic step(input string req, input logic [3:0] exp_upc, input logic [5:0] opc);
        check_state(req, exp_upc);
        opcode = opc;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_state("R1", 4'd0);
        rst = 1'b0;

        // table walk: R2, R3, R4, R6, R7, R8, R9, R10, R5
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < int'(VEC[v][22:20]); k++) begin
                step("R3", VEC[v][4*k +: 4], VEC[v][28:23]);
            end
        end
        check_state("R5", 4'd0);

        // R5: second table with an opcode it does not list
        step("R2", 4'd0, 6'h23);
        step("R3", 4'd1, 6'h23);
        step("R4", 4'd2, 6'h00);
        check_state("R5", 4'd0);

        // R11: opcode changes outside the lookup steps are ignored
        step("R11", 4'd0, 6'h04);
        step("R11", 4'd1, 6'h2B);
        step("R11", 4'd2, 6'h23);
        step("R11", 4'd3, 6'h02);
        step("R11", 4'd4, 6'h00);
        step("R11", 4'd0, 6'h00);
        step("R11", 4'd1, 6'h00);
        step("R11", 4'd6, 6'h2B);
        step("R11", 4'd7, 6'h04);
        check_state("R11", 4'd0);

        // R1: reset in the middle of an instruction
        step("R1", 4'd0, 6'h00);
        step("R1", 4'd1, 6'h00);
        check_state("R1", 4'd6);
        rst = 1'b1;
        @(negedge clk);
        check_state("R1", 4'd0);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1", 4'd1);

        finish_run();
    end
endmodule